// File: doc/BRIEF.md
# Dual-CPU Doorbell Interrupt Mailbox

This block lets processors ring each other through interrupt lines. Each CPU owns a small bank of doorbell bits. A level interrupt goes to that CPU while any of its bits is set. The bits change only through two write-only aliases: one sets bits and one clears them. Each bank also has a read-only status view. Because of this, a sender can raise a bit and a receiver can acknowledge it without a read-modify-write race.

The block is a 32-bit APB-style slave over a 4 KB window with zero wait states. A read-only table of twelve identification bytes sits at the top of the window. Accesses that go the wrong way are flagged with a one-cycle slave error, and so are accesses that land on nothing. Such accesses change no state and read back as zero.

Top module: `dbell_mbox`

## Requirements
- R1: The registers of CPU n sit at offset 0x10*n: status at +0x0, set at +0x4 and clear at +0x8. With the default two CPUs this gives 0x000/0x004/0x008 and 0x010/0x014/0x018. The banks are independent.
- R2: A write to a set register ORs pwdata[3:0] into that CPU's doorbell bits. pwdata[31:4] is ignored.
- R3: A write to a clear register clears each doorbell bit whose bit in pwdata[3:0] is 1. The other bits keep their value and pwdata[31:4] is ignored.
- R4: irq[n] is high exactly when CPU n has a doorbell bit at 1. It is registered: during the access phase of a write it still shows the old state, and it shows the new state from the clock edge that completes the write. It does not change without a write.
- R5: A read of a status register returns that CPU's bits in prdata[3:0], with prdata[31:4] = 0 and no error. A read of a set or clear register returns 0 with pslverr = 1.
- R6: A write to a status register or to an ID register changes nothing and raises pslverr.
- R7: A read of the words at 0xFD0, 0xFD4, ... 0xFFC returns, in address order, 0x04, 0x00, 0x00, 0x00, 0x56, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in prdata[7:0]. The upper bits read 0 and no error is raised.
- R8: An access to any other offset is unmapped and raises pslverr. This includes 0x00C, offsets beyond the last CPU and offsets that are not word-aligned. A read returns 0 and a write changes nothing.
- R9: pready is always 1. pslverr is high only in the access phase (psel and penable both 1), so it lasts one cycle per transfer.
- R10: A synchronous active-high reset clears every doorbell bit and drives both irq outputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | 12 | Byte offset in the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Transfer ready, constant 1 |
| pslverr | output | 1 | Error for a wrong-direction or unmapped access |
| irq | output | NUM_CPU | Level interrupt, one per CPU |

## Verification
The bench builds the block with its defaults, which are two CPUs and four doorbell bits per CPU. With these values the second bank's registers at 0x010–0x018 sit next to the unmapped gap at 0x00C and the unmapped space from 0x020 up. The bench can therefore show that the banks are independent and that the decode edges are exact. The four-bit width also brings the mask boundary within reach: set and clear data with only bits 31:4 set must leave the bank untouched.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

    // Window layout constants (4 KB window, word registers)
    localparam int          WIN_ADDR_W = 12;
    localparam int          BUS_W      = 32;
    localparam int          CPU_SEL_W  = 4;      // up to 16 CPU slots of 16 bytes
    localparam int          ID_IDX_W   = 4;
    localparam int          ID_COUNT   = 12;
    localparam logic [11:0] ID_BASE    = 12'hFD0;

    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_STAT,
        KIND_SET,
        KIND_CLR,
        KIND_ID
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e              kind;
        logic [CPU_SEL_W-1:0]   cpu;
        logic [ID_IDX_W-1:0]    id_idx;
    } reg_hit_t;

    // Identification bytes, one per word, lowest address first
    function automatic logic [7:0] id_byte(input logic [ID_IDX_W-1:0] idx);
        case (idx)
            4'd0:    return 8'h04;
            4'd4:    return 8'h56;
            4'd5:    return 8'hB8;
            4'd6:    return 8'h0B;
            4'd8:    return 8'h0D;
            4'd9:    return 8'hF0;
            4'd10:   return 8'h05;
            4'd11:   return 8'hB1;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
    import dbell_pkg::*;
#(
    parameter int NUM_CPU = 2
) (
    input  logic [WIN_ADDR_W-1:0] addr,
    output reg_hit_t              hit
);

    always_comb begin
        hit        = '0;
        hit.kind   = KIND_NONE;
        hit.cpu    = addr[7:4];
        hit.id_idx = ID_IDX_W'((addr - ID_BASE) >> 2);
        if (addr[1:0] != 2'b00) begin
            hit.kind = KIND_NONE;
        end else if (addr >= ID_BASE) begin
            hit.kind = KIND_ID;
        end else if (addr[11:8] == 4'h0 && int'(addr[7:4]) < NUM_CPU) begin
            case (addr[3:2])
                2'd0:    hit.kind = KIND_STAT;
                2'd1:    hit.kind = KIND_SET;
                2'd2:    hit.kind = KIND_CLR;
                default: hit.kind = KIND_NONE;
            endcase
        end
    end

endmodule

// File: rtl/dbell_bank.sv
module dbell_bank #(
    parameter int BELL_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [BELL_W-1:0] wmask,
    output logic [BELL_W-1:0] bells,
    output logic              irq
);

    logic [BELL_W-1:0] bells_nxt;

    always_comb begin
        bells_nxt = bells;
        if (set_we) bells_nxt = bells_nxt | wmask;
        if (clr_we) bells_nxt = bells_nxt & ~wmask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bells <= '0;
            irq   <= 1'b0;
        end else begin
            bells <= bells_nxt;
            irq   <= |bells_nxt;
        end
    end

endmodule

// File: rtl/dbell_mbox.sv
module dbell_mbox
    import dbell_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int BELL_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  psel,
    input  logic                  penable,
    input  logic                  pwrite,
    input  logic [WIN_ADDR_W-1:0] paddr,
    input  logic [BUS_W-1:0]      pwdata,
    output logic [BUS_W-1:0]      prdata,
    output logic                  pready,
    output logic                  pslverr,
    output logic [NUM_CPU-1:0]    irq
);

    reg_hit_t                      hit;
    logic                          access;
    logic                          legal;
    logic [NUM_CPU-1:0][BELL_W-1:0] bells;
    logic [BELL_W-1:0]             sel_bells;
    logic                          wdata_unused;

    assign wdata_unused = ^pwdata[BUS_W-1:BELL_W];
    assign access       = psel & penable;
    assign pready       = 1'b1;

    dbell_decode #(.NUM_CPU(NUM_CPU)) u_decode (
        .addr (paddr),
        .hit  (hit)
    );

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_bank
        logic mine;
        assign mine = access & pwrite & (hit.cpu == CPU_SEL_W'(g));
        dbell_bank #(.BELL_W(BELL_W)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .set_we (mine & (hit.kind == KIND_SET)),
            .clr_we (mine & (hit.kind == KIND_CLR)),
            .wmask  (pwdata[BELL_W-1:0]),
            .bells  (bells[g]),
            .irq    (irq[g])
        );
    end

    always_comb begin
        sel_bells = '0;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (hit.cpu == CPU_SEL_W'(i)) sel_bells = bells[i];
        end
    end

    // Direction legality per register kind
    always_comb begin
        if (pwrite) legal = (hit.kind == KIND_SET) || (hit.kind == KIND_CLR);
        else        legal = (hit.kind == KIND_STAT) || (hit.kind == KIND_ID);
    end

    assign pslverr = access & ~legal;

    always_comb begin
        prdata = '0;
        if (access && !pwrite) begin
            case (hit.kind)
                KIND_STAT: prdata = BUS_W'(sel_bells);
                KIND_ID:   prdata = BUS_W'(id_byte(hit.id_idx));
                default:   prdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dbell_mbox_chk.sv
module dbell_mbox_chk #(
    parameter int NUM_CPU = 2,
    parameter int BELL_W  = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               psel,
    input logic               penable,
    input logic               pwrite,
    input logic [11:0]        paddr,
    input logic [31:0]        pwdata,
    input logic [31:0]        prdata,
    input logic               pready,
    input logic               pslverr,
    input logic [NUM_CPU-1:0] irq
);

    logic acc;
    assign acc = psel && penable;

    AST_READY_HIGH: assert property (@(posedge clk) disable iff (rst) pready); // R9
    AST_ERR_ONLY_ACCESS: assert property (@(posedge clk) disable iff (rst) !acc |-> !pslverr); // R9
    AST_IRQ_RESET_LOW: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> irq == '0); // R10
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst) !(acc && pwrite) |=> $stable(irq)); // R4
    AST_MISALIGNED_ERR: assert property (@(posedge clk) disable iff (rst)
        acc && paddr[1:0] != 2'b00 |-> pslverr && prdata == 32'h0); // R8
    AST_ID_READ_CLEAN: assert property (@(posedge clk) disable iff (rst)
        acc && !pwrite && paddr >= 12'hFD0 && paddr[1:0] == 2'b00 |-> !pslverr && prdata[31:8] == 24'h0); // R7

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
        localparam logic [11:0] STAT_A = 12'(g * 16);
        localparam logic [11:0] SET_A  = 12'(g * 16 + 4);
        localparam logic [11:0] CLR_A  = 12'(g * 16 + 8);

        AST_SET_RAISES: assert property (@(posedge clk) disable iff (rst)
            acc && pwrite && paddr == SET_A && pwdata[BELL_W-1:0] != '0 |=> irq[g]); // R2
        AST_CLR_ALL_DROPS: assert property (@(posedge clk) disable iff (rst)
            acc && pwrite && paddr == CLR_A && (&pwdata[BELL_W-1:0]) |=> !irq[g]); // R3
        AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
            acc && !pwrite && (paddr == SET_A || paddr == CLR_A) |-> prdata == 32'h0 && pslverr); // R5
        AST_STAT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
            acc && pwrite && paddr == STAT_A |-> pslverr ##1 $stable(irq)); // R6
    end

endmodule

bind dbell_mbox dbell_mbox_chk #(.NUM_CPU(NUM_CPU), .BELL_W(BELL_W)) u_chk (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .irq(irq)
);

// File: tb/test_dbell_mbox.sv
module test_dbell_mbox;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;
    logic [1:0]  irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    bit setup_err_seen = 0;
    logic [1:0] irq_acc;

    always #2.5 clk = ~clk;   // 200 MHz

    dbell_mbox i_dbell_mbox (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .irq(irq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic xfer(input bit w, input logic [11:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic err);
        @(posedge clk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = w; paddr = a; pwdata = d;
        #1;
        if (pslverr !== 1'b0) setup_err_seen = 1;
        @(posedge clk); #1;
        penable = 1'b1;
        #1;
        rd = prdata; err = pslverr; irq_acc = irq;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, output logic err);
        logic [31:0] rd;
        xfer(1'b1, a, d, rd, err);
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp, input logic exp_err);
        logic [31:0] rd;
        logic err;
        xfer(1'b0, a, 32'h0, rd, err);
        chk(req, $sformatf("read data @0x%03h", a), rd, exp);
        chk(req, $sformatf("read err @0x%03h", a), {31'h0, err}, {31'h0, exp_err});
    endtask

    task automatic t_reset;
        chk("R10", "irq after reset", {30'h0, irq}, 32'h0);
        chk("R9", "pready idle", {31'h0, pready}, 32'h1);
        chk("R9", "pslverr idle", {31'h0, pslverr}, 32'h0);
        rd_chk("R10", 12'h000, 32'h0, 1'b0);
        rd_chk("R10", 12'h010, 32'h0, 1'b0);
    endtask

    task automatic t_set;
        logic err;
        wr(12'h004, 32'hFFFF_FFF5, err);
        chk("R2", "set err", {31'h0, err}, 32'h0);
        chk("R4", "irq in access phase still old", {30'h0, irq_acc}, 32'h0);
        chk("R4", "irq after set cpu0", {30'h0, irq}, 32'h1);
        rd_chk("R2", 12'h000, 32'h5, 1'b0);
        wr(12'h014, 32'h0000_0002, err);
        chk("R1", "irq after set cpu1", {30'h0, irq}, 32'h3);
        rd_chk("R1", 12'h010, 32'h2, 1'b0);
        wr(12'h004, 32'h0000_0002, err);
        rd_chk("R2", 12'h000, 32'h7, 1'b0);
        wr(12'h004, 32'hFFFF_FFF0, err);
        rd_chk("R2", 12'h000, 32'h7, 1'b0);
    endtask

    task automatic t_clear;
        logic err;
        wr(12'h008, 32'h1, err);
        chk("R3", "clr err", {31'h0, err}, 32'h0);
        rd_chk("R3", 12'h000, 32'h6, 1'b0);
        wr(12'h008, 32'hFFFF_FFF0, err);
        rd_chk("R3", 12'h000, 32'h6, 1'b0);
        wr(12'h008, 32'h6, err);
        chk("R4", "irq in access phase before clear", {30'h0, irq_acc}, 32'h3);
        chk("R4", "irq after full clear", {30'h0, irq}, 32'h2);
        rd_chk("R3", 12'h000, 32'h0, 1'b0);
        rd_chk("R1", 12'h010, 32'h2, 1'b0);
        wr(12'h018, 32'h2, err);
        chk("R3", "irq cpu1 cleared", {30'h0, irq}, 32'h0);
    endtask

    task automatic t_wo_read;
        logic err;
        wr(12'h014, 32'h9, err);
        rd_chk("R5", 12'h014, 32'h0, 1'b1);
        rd_chk("R5", 12'h018, 32'h0, 1'b1);
        rd_chk("R5", 12'h004, 32'h0, 1'b1);
        rd_chk("R5", 12'h010, 32'h9, 1'b0);
    endtask

    task automatic t_ro_write;
        logic err;
        wr(12'h010, 32'h0, err);
        chk("R6", "status write err", {31'h0, err}, 32'h1);
        rd_chk("R6", 12'h010, 32'h9, 1'b0);
        wr(12'h000, 32'hF, err);
        chk("R6", "status write err cpu0", {31'h0, err}, 32'h1);
        chk("R6", "irq unchanged", {30'h0, irq}, 32'h2);
        rd_chk("R6", 12'h000, 32'h0, 1'b0);
        wr(12'hFD0, 32'hFF, err);
        chk("R6", "id write err", {31'h0, err}, 32'h1);
        rd_chk("R6", 12'hFD0, 32'h04, 1'b0);
    endtask

    task automatic t_id;
        logic [7:0] exp_id [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h56, 8'hB8,
                                    8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int k = 0; k < 12; k++) begin
            rd_chk("R7", 12'(12'hFD0 + k * 4), {24'h0, exp_id[k]}, 1'b0);
        end
    endtask

    task automatic t_unmapped;
        logic err;
        rd_chk("R8", 12'h00C, 32'h0, 1'b1);
        rd_chk("R8", 12'h020, 32'h0, 1'b1);
        rd_chk("R8", 12'hFCC, 32'h0, 1'b1);
        rd_chk("R8", 12'h011, 32'h0, 1'b1);
        wr(12'h00C, 32'hF, err);
        chk("R8", "write gap err", {31'h0, err}, 32'h1);
        wr(12'h006, 32'hF, err);
        chk("R8", "misaligned write err", {31'h0, err}, 32'h1);
        wr(12'h024, 32'hF, err);
        chk("R8", "irq after unmapped writes", {30'h0, irq}, 32'h2);
        rd_chk("R8", 12'h000, 32'h0, 1'b0);
        rd_chk("R8", 12'h010, 32'h9, 1'b0);
    endtask

    task automatic t_reset_again;
        @(posedge clk); #1; rst = 1'b1;
        @(posedge clk); #1; rst = 1'b0;
        chk("R10", "irq after second reset", {30'h0, irq}, 32'h0);
        rd_chk("R10", 12'h010, 32'h0, 1'b0);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_set();
        t_clear();
        t_wo_read();
        t_ro_write();
        t_id();
        t_unmapped();
        chk("R9", "no error in setup phase", {31'h0, setup_err_seen}, 32'h0);
        t_reset_again();
        summary();
    end

endmodule